// File: doc/BRIEF.md
# Radio Slot Timing Sequencer

This block sits on the baseband side of a short-range frequency-hopping radio. It drives the radio's power-up and mode lines for a single transmit or receive burst lasting one, three or five slots. A one-cycle start request comes with three inputs: a direction bit, a two-bit slot-length code and an option bit for late falling edges. The sequencer samples all three, then steps through a fixed series of phases. Each phase is timed in microseconds by a tick that is divided down from the reference clock.

In a transmit burst, the synthesizer enable and the transmitter enable rise together. After a warm-up delay, the loop-open line rises, which opens the synthesizer PLL so that modulation data reaches the carrier. In a receive burst, the receiver enable rises with the synthesizer. After the warm-up delay, a header phase runs first. The payload flag is then raised, so that the frequency-compensation loop changes from fast tracking to slow tracking for the rest of the window. Two one-cycle pulses mark the cycle in which the data window opens and the cycle in which it closes. The shutdown order never varies: the loop-open line or payload flag drops first, then the transmit or receive enable, then the synthesizer. A start request that arrives while a burst is in progress is dropped and reported.

States: `S_IDLE`, `S_WARM`, `S_HEAD`, `S_BODY`, `S_HOLD`, `S_PATH_OFF`, `S_SYN_OFF`.

Transitions:
- `S_IDLE` goes to `S_WARM` on start.
- `S_WARM` goes to `S_BODY` (transmit) or `S_HEAD` (receive) when its timer expires.
- `S_HEAD` goes to `S_BODY` when its timer expires.
- `S_BODY` goes to `S_HOLD` (transmit with the late option) or `S_PATH_OFF` (all other cases) when its timer expires.
- `S_HOLD` goes to `S_PATH_OFF` when its timer expires.
- `S_PATH_OFF` goes to `S_SYN_OFF` after one cycle.
- `S_SYN_OFF` goes to `S_IDLE` after one cycle, or after its timer expires when the late option is set.

Top module: `slot_seq`

## Requirements
- R1: After reset, every output is low and the block is idle.
- R2: When start_i is high in idle, the block samples tx_dir_i (1 = transmit, 0 = receive), slot_code_i and late_fall_i. In the next cycle busy_o and synth_en_o are high, together with tx_en_o (transmit) or rx_en_o (receive).
- R3: In a transmit burst, loop_open_o rises TX_WARM_US microseconds after the enables rise. A microsecond is CLK_PER_US clock cycles. win_open_o pulses for one cycle as loop_open_o rises.
- R4: The data window lasts LEN1_US for slot code 00 (one slot), LEN3_US for code 01 (three slots) and LEN5_US for code 10 (five slots). Code 11 behaves like code 00. win_close_o pulses in the first cycle after the window.
- R5: In a receive burst, win_open_o pulses RX_WARM_US microseconds after the enables rise. payload_o rises HDR_US microseconds after that and stays high until the window ends.
- R6: tx_en_o and rx_en_o are never high together. loop_open_o is high only while synth_en_o and tx_en_o are high. payload_o is high only while synth_en_o and rx_en_o are high.
- R7: Without the late option, shutdown takes one cycle per step, in this order: loop_open_o or payload_o drops, then tx_en_o or rx_en_o drops, then synth_en_o drops and busy_o clears.
- R8: With the late option, in a transmit burst loop_open_o stays high LATE_US microseconds past the window close. In any burst, synth_en_o stays high LATE_US microseconds after the path enable drops.
- R9: A start_i received while busy has no effect on the running burst, and start_err_o pulses for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| tx_dir_i | input | 1 | 1 = transmit, 0 = receive |
| slot_code_i | input | 2 | Burst length: 00 one slot, 01 three slots, 10 five slots, 11 one slot |
| late_fall_i | input | 1 | Delay the falls of the loop-open line and the synthesizer by LATE_US |
| synth_en_o | output | 1 | Synthesizer power enable |
| tx_en_o | output | 1 | Transmitter enable |
| loop_open_o | output | 1 | Opens the PLL and gates transmit data |
| rx_en_o | output | 1 | Receiver enable |
| payload_o | output | 1 | Receive payload flag (slow compensation) |
| win_open_o | output | 1 | One-cycle pulse when the data window opens |
| win_close_o | output | 1 | One-cycle pulse when the data window closes |
| busy_o | output | 1 | Burst in progress |
| start_err_o | output | 1 | One-cycle pulse for a start request that was dropped |

## Verification
The bench aims at the exact cycle of every edge: each state must run for its microsecond count times the divider ratio. A design that leaves the divider running across states would be up to one microsecond off, and the scoreboard would see the edge early. The bench also covers slot code 11 and all three burst lengths, so a bad length table or a missing default shows up as a wrong window. It runs shutdown with and without the late option, so swapped edge order or a hold applied to the wrong line gives an out-of-order event. Finally, it injects a start request during a burst; a design that restarts or changes direction would produce events the queue does not hold.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WARM,
        S_HEAD,
        S_BODY,
        S_HOLD,
        S_PATH_OFF,
        S_SYN_OFF
    } seq_state_t;

    typedef enum logic [1:0] {
        LEN_ONE   = 2'b00,
        LEN_THREE = 2'b01,
        LEN_FIVE  = 2'b10,
        LEN_ALT   = 2'b11
    } slot_code_t;

endpackage

// File: rtl/sseq_us_tick.sv
module sseq_us_tick #(
    parameter int CLK_PER_US = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr || tick)   cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sseq_us_timer.sv
module sseq_us_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         done
);
    logic [W-1:0] us_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     us_q <= '0;
        else if (clr)   us_q <= '0;
        else if (tick)  us_q <= us_q + 1'b1;
    end

    assign done = tick && (us_q == target - 1'b1);
endmodule

// File: rtl/slot_seq.sv
module slot_seq
    import sseq_pkg::*;
#(
    parameter int CLK_PER_US = 13,
    parameter int TX_WARM_US = 213,
    parameter int RX_WARM_US = 213,
    parameter int HDR_US     = 126,
    parameter int LATE_US    = 6,
    parameter int LEN1_US    = 366,
    parameter int LEN3_US    = 1598,
    parameter int LEN5_US    = 2862
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tx_dir_i,
    input  logic [1:0] slot_code_i,
    input  logic       late_fall_i,
    output logic       synth_en_o,
    output logic       tx_en_o,
    output logic       loop_open_o,
    output logic       rx_en_o,
    output logic       payload_o,
    output logic       win_open_o,
    output logic       win_close_o,
    output logic       busy_o,
    output logic       start_err_o
);
    localparam int MAX_US = (LEN5_US > TX_WARM_US) ? LEN5_US : TX_WARM_US;
    localparam int US_W   = $clog2(MAX_US + 2);

    seq_state_t  state_q, state_nx, prev_q;
    logic        dir_q, late_q, err_q;
    slot_code_t  code_q;
    logic [US_W-1:0] len_us, target;
    logic        tick, done, ld;

    assign ld = (state_nx != state_q);

    sseq_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(ld), .tick(tick)
    );

    sseq_us_timer #(.W(US_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(ld), .tick(tick),
        .target(target), .done(done)
    );

    // Window length per slot code; the spare code maps to one slot.
    always_comb begin
        unique case (code_q)
            LEN_THREE: len_us = US_W'(LEN3_US);
            LEN_FIVE:  len_us = US_W'(LEN5_US);
            default:   len_us = US_W'(LEN1_US);
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_WARM:  target = dir_q ? US_W'(TX_WARM_US) : US_W'(RX_WARM_US);
            S_HEAD:  target = US_W'(HDR_US);
            S_BODY:  target = dir_q ? len_us : len_us - US_W'(HDR_US);
            default: target = US_W'(LATE_US);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_nx = S_WARM;
            S_WARM:     if (done) state_nx = dir_q ? S_BODY : S_HEAD;
            S_HEAD:     if (done) state_nx = S_BODY;
            S_BODY:     if (done) state_nx = (dir_q && late_q) ? S_HOLD : S_PATH_OFF;
            S_HOLD:     if (done) state_nx = S_PATH_OFF;
            S_PATH_OFF: state_nx = S_SYN_OFF;
            S_SYN_OFF:  if (!late_q || done) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register with burst parameters captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            prev_q  <= S_IDLE;
            dir_q   <= 1'b0;
            late_q  <= 1'b0;
            code_q  <= LEN_ONE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            prev_q  <= state_q;
            err_q   <= start_i && (state_q != S_IDLE);
            if (state_q == S_IDLE && start_i) begin
                dir_q  <= tx_dir_i;
                late_q <= late_fall_i;
                code_q <= slot_code_t'(slot_code_i);
            end
        end
    end

    // Output decode
    always_comb begin
        synth_en_o  = 1'b0;
        tx_en_o     = 1'b0;
        rx_en_o     = 1'b0;
        loop_open_o = 1'b0;
        payload_o   = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_WARM, S_HEAD, S_PATH_OFF: begin
                synth_en_o = 1'b1;
                tx_en_o    = dir_q;
                rx_en_o    = !dir_q;
            end
            S_BODY, S_HOLD: begin
                synth_en_o  = 1'b1;
                tx_en_o     = dir_q;
                rx_en_o     = !dir_q;
                loop_open_o = dir_q;
                payload_o   = !dir_q;
            end
            S_SYN_OFF: synth_en_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o      = (state_q != S_IDLE);
    assign start_err_o = err_q;
    assign win_open_o  = (prev_q == S_WARM) && (state_q != S_WARM);
    assign win_close_o = (prev_q == S_BODY) && (state_q != S_BODY);
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic synth_en_o,
    input logic tx_en_o,
    input logic loop_open_o,
    input logic rx_en_o,
    input logic payload_o,
    input logic busy_o,
    input logic start_err_o
);
    p_path_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en_o && rx_en_o));

    p_loop_needs_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loop_open_o |-> (synth_en_o && tx_en_o));

    p_payload_needs_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        payload_o |-> (synth_en_o && rx_en_o));

    p_synth_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(synth_en_o) |-> $past(!tx_en_o && !rx_en_o));

    p_tx_after_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en_o) |-> $past(!loop_open_o));

    p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && synth_en_o && !start_err_o));

    p_busy_start_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> start_err_o);
endmodule

bind slot_seq sseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .synth_en_o(synth_en_o), .tx_en_o(tx_en_o), .loop_open_o(loop_open_o),
    .rx_en_o(rx_en_o), .payload_o(payload_o), .busy_o(busy_o),
    .start_err_o(start_err_o)
);

// File: tb/slot_seq_tb.sv
module slot_seq_tb;
    localparam int D    = 4;
    localparam int TXW  = 213;
    localparam int RXW  = 213;
    localparam int HDR  = 126;
    localparam int LATE = 6;
    localparam int L1 = 366, L3 = 1598, L5 = 2862;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, dir = 1'b0, late = 1'b0;
    logic [1:0] code = 2'b00;
    logic synth, txe, loopo, rxe, pay, wopen, wclose, busy, err;

    int checks = 0, errors = 0;
    int cyc = 0;
    int inv_bad = 0;

    typedef struct { int t; logic [7:0] v; } ev_t;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slot_seq #(.CLK_PER_US(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tx_dir_i(dir),
        .slot_code_i(code), .late_fall_i(late),
        .synth_en_o(synth), .tx_en_o(txe), .loop_open_o(loopo),
        .rx_en_o(rxe), .payload_o(pay), .win_open_o(wopen),
        .win_close_o(wclose), .busy_o(busy), .start_err_o(err)
    );

    // vector: {busy, synth, tx, loop, rx, payload, win_open, win_close}
    function automatic logic [7:0] vec_now();
        return {busy, synth, txe, loopo, rxe, pay, wopen, wclose};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int t, input logic [7:0] v);
        ev_t e;
        e.t = t; e.v = v;
        exp_q.push_back(e);
    endtask

    // Monitor: every change of the output vector must match the next queued event.
    logic [7:0] last_v = 8'h00;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] v;
            v = vec_now();
            if ((txe && rxe) || (loopo && !(synth && txe)) || (pay && !(synth && rxe)))
                inv_bad++;
            if (v != last_v) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2-R9 unexpected event", v, last_v);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(v == e.v, "R2-R9 event value", v, e.v);
                    chk(cyc == e.t, "R3/R4/R5/R7/R8 event time", cyc, e.t);
                end
                last_v = v;
            end
        end
    end

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'b01:   return L3;
            2'b10:   return L5;
            default: return L1;
        endcase
    endfunction

    // Driver: queue the expected events, then launch the burst.
    task automatic run(input bit tx, input logic [1:0] c, input bit lt, input bit inject);
        int t0, t1, t2, t3, l;
        @(negedge clk);
        inv_bad = 0;
        l  = len_of(c);
        t0 = cyc + 1;
        if (tx) begin
            // R2 R3 R4 R7 R8
            t1 = t0 + TXW * D;
            t2 = t1 + l * D;
            push(t0, 8'b1110_0000);
            push(t1, 8'b1111_0010);
            push(t1 + 1, 8'b1111_0000);
            if (lt) begin
                push(t2, 8'b1111_0001);
                push(t2 + 1, 8'b1111_0000);
                t3 = t2 + LATE * D;
                push(t3, 8'b1110_0000);
                push(t3 + 1, 8'b1100_0000);
                push(t3 + 1 + LATE * D, 8'b0000_0000);
            end else begin
                push(t2, 8'b1110_0001);
                push(t2 + 1, 8'b1100_0000);
                push(t2 + 2, 8'b0000_0000);
            end
        end else begin
            // R2 R5 R4 R7 R8
            t1 = t0 + RXW * D;
            t2 = t1 + HDR * D;
            t3 = t2 + (l - HDR) * D;
            push(t0, 8'b1100_1000);
            push(t1, 8'b1100_1010);
            push(t1 + 1, 8'b1100_1000);
            push(t2, 8'b1100_1100);
            push(t3, 8'b1100_1001);
            push(t3 + 1, 8'b1100_0000);
            push(lt ? t3 + 1 + LATE * D : t3 + 2, 8'b0000_0000);
        end
        dir = tx; code = c; late = lt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0, "R2 no error on idle start", err, 0);
        if (inject) begin
            repeat (10) @(negedge clk);
            dir = !tx; code = 2'b10; late = !lt; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(err == 1'b1, "R9 error pulse on busy start", err, 1);
            @(negedge clk);
            chk(err == 1'b0, "R9 error pulse one cycle", err, 0);
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2-R9 all events seen", exp_q.size(), 0);
        chk(inv_bad == 0, "R6 exclusion and gating", inv_bad, 0);
        exp_q.delete();
    endtask

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vec_now() == 8'h00, "R1 outputs low after reset", vec_now(), 0);
        chk(err == 1'b0, "R1 error flag low after reset", err, 0);

        run(1'b1, 2'b00, 1'b0, 1'b0);  // R3 R4 R7 transmit one slot
        run(1'b0, 2'b00, 1'b0, 1'b0);  // R5 receive one slot
        run(1'b1, 2'b01, 1'b0, 1'b1);  // R4 three slots, R9 busy start
        run(1'b0, 2'b10, 1'b1, 1'b0);  // R5 R8 five slots receive late
        run(1'b1, 2'b11, 1'b1, 1'b1);  // R4 spare code, R8 late, R9
        run(1'b0, 2'b01, 1'b0, 1'b1);  // R9 during receive

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule